// File: doc/BRIEF.md
# Per-Output Queued Cell Buffer for a Switch Input

This block sits at one ingress port of a cell switch. Each arriving cell has a fixed length and carries a destination index. The block files the cell into one of several logical queues, one for each switch output, all held in a single shared cell store. Each queue is a linked chain of storage slots. A free-slot ring recycles slots as cells leave, so any queue can use any part of the capacity.

Toward an external matching scheduler, the block reports two things for each output: a request bit and the number of waiting cells. The scheduler answers with a grant vector. When exactly one grant bit is set and that queue is not empty, the oldest cell of that queue is read out one cycle later. A head cell that is waiting for one output never holds back cells bound for other outputs.

If the shared store is full, the block raises a backpressure flag and refuses new cells. A grant that cannot be served is ignored and leaves a sticky error flag.

Top module: `vqInputBuffer`

## Requirements
- R1: A cell presented with `wrValid` high while `full` is low is accepted into the queue named by `wrDest` (binary output index). That queue's count in `occFlat` (field j at bits j*CNT_W upward) rises by one after the accepting clock edge.
- R2: After every clock edge, `reqVec[j]` is 1 exactly when the count of queue j is non-zero.
- R3: A grant whose only set bit is bit j, arriving while queue j holds at least one cell, makes `rdValid` high on the next cycle. `rdData` then carries the oldest cell of queue j. Within a queue, cells leave in the order they arrived.
- R4: Serving one queue changes neither the count nor the cell order of any other queue.
- R5: `full` is high exactly when the number of stored cells equals the capacity. A cell offered while `full` is high is not accepted, and no count changes because of it.
- R6: If a cell is accepted into queue j and queue j is also served in the same cycle, the count of queue j is unchanged. The surviving cells still leave in arrival order.
- R7: A non-zero grant that is not one-hot, or that names a queue whose count is zero at that edge, is ignored: `rdValid` stays low and no count drops. A cell written into an empty queue in that same cycle is therefore not served until a later cycle. Such a grant sets `grantErr`, which stays high until reset.
- R8: Reset (`rstN` low) empties every queue. After reset the counts, `reqVec`, `full`, `rdValid` and `grantErr` are all zero.
- R9: Slots released by served cells become available again. After the store has been filled and drained, it can take a full capacity of cells again, whatever their destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Cell offered this cycle |
| wrDest | input | DEST_W | Destination output index of the offered cell |
| wrData | input | VQ_CELL_W | Cell contents |
| full | output | 1 | Backpressure: shared store holds its capacity |
| reqVec | output | VQ_OUTPUTS | Per-output request, set while that queue is non-empty |
| occFlat | output | VQ_OUTPUTS*CNT_W | Packed per-output cell counts |
| grant | input | VQ_OUTPUTS | Scheduler grant, expected one-hot or zero |
| rdValid | output | 1 | Cell present on `rdData` |
| rdData | output | VQ_CELL_W | Dequeued cell |
| grantErr | output | 1 | Sticky flag for a grant that could not be served |

## Verification
Every result of this block is registered once. A cell accepted at an edge shows up in its queue's count, in the request bit and in `full` right after that edge. A served grant puts `rdValid` and the cell on `rdData` after the same edge. `grantErr` also follows the offending edge directly.

The bench drives each stimulus on a falling edge and lets one rising edge pass. It compares every output at the next falling edge against a queue model that it updates with the same cycle rules. Directed phases cover fill to capacity, refusal while full, draining, refilling into a single queue, a write and a grant on the same queue, and a grant on the same edge as a write into an empty queue. A long pseudo-random phase covers the mixed cases.

// File: rtl/vqPkg.sv
package vqPkg;
  parameter int unsigned VQ_OUTPUTS = 4;
  parameter int unsigned VQ_SLOTS   = 8;
  parameter int unsigned VQ_CELL_W  = 16;

  localparam int unsigned DEST_W = (VQ_OUTPUTS > 1) ? $clog2(VQ_OUTPUTS) : 1;
  localparam int unsigned SLOT_W = (VQ_SLOTS > 1) ? $clog2(VQ_SLOTS) : 1;
  localparam int unsigned CNT_W  = $clog2(VQ_SLOTS + 1);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic  cellWr;     // store incoming cell
    slot_t cellAddr;
    logic  linkWr;     // chain new slot behind a tail
    slot_t linkAddr;
    slot_t linkData;
    logic  freeWr;     // return a released slot to the ring
    slot_t freeWrAddr;
    slot_t freeData;
    slot_t freeRdAddr; // ring position of next free slot
    logic  rdEn;       // read a head cell out
    slot_t rdAddr;
  } vqStrobe_t;
endpackage

// File: rtl/vqDatapath.sv
module vqDatapath
  import vqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  vqStrobe_t            strobe,
  input  logic [VQ_CELL_W-1:0] wrData,
  output slot_t                freeHead,
  output slot_t                linkNext,
  output logic                 rdValid,
  output logic [VQ_CELL_W-1:0] rdData
);
  logic [VQ_CELL_W-1:0] cellMem [VQ_SLOTS];
  slot_t                linkMem [VQ_SLOTS];
  slot_t                freeMem [VQ_SLOTS];

  assign freeHead = freeMem[strobe.freeRdAddr];
  assign linkNext = linkMem[strobe.rdAddr];

  always_ff @(posedge clk) begin
    if (strobe.cellWr) cellMem[strobe.cellAddr] <= wrData;
    if (strobe.linkWr) linkMem[strobe.linkAddr] <= strobe.linkData;
  end

  // Free ring starts out holding every slot index.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < VQ_SLOTS; i++) freeMem[i] <= slot_t'(i);
    end else if (strobe.freeWr) begin
      freeMem[strobe.freeWrAddr] <= strobe.freeData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= cellMem[strobe.rdAddr];
    end
  end

  // Store and readout never target one slot in the same cycle.
  p_no_slot_clash_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cellWr && strobe.rdEn) |-> (strobe.cellAddr != strobe.rdAddr));
endmodule

// File: rtl/vqControl.sv
module vqControl
  import vqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [DEST_W-1:0]     wrDest,
  input  logic [VQ_OUTPUTS-1:0] grant,
  input  slot_t                 freeHead,
  input  slot_t                 linkNext,
  output vqStrobe_t             strobe,
  output cnt_t                  occ [VQ_OUTPUTS],
  output logic                  full,
  output logic                  grantErr
);
  slot_t headPtr [VQ_OUTPUTS];
  slot_t tailPtr [VQ_OUTPUTS];
  slot_t freeRd, freeWr;
  cnt_t  freeCnt;

  logic [DEST_W-1:0] gIdx;
  logic              gOne, deq, enq, destOk, sameQ;

  always_comb begin
    gIdx = '0;
    for (int j = 0; j < VQ_OUTPUTS; j++)
      if (grant[j]) gIdx = DEST_W'(j);
  end

  assign gOne   = $onehot(grant);
  assign deq    = gOne && (occ[gIdx] != '0);
  assign destOk = (32'(wrDest) < VQ_OUTPUTS);
  assign enq    = wrValid && destOk && (freeCnt != '0);
  assign sameQ  = deq && enq && (gIdx == wrDest);
  assign full   = (freeCnt == '0);

  always_comb begin
    strobe            = '0;
    strobe.cellWr     = enq;
    strobe.cellAddr   = freeHead;
    strobe.linkWr     = enq && (occ[wrDest] != '0) && !(sameQ && occ[wrDest] == cnt_t'(1));
    strobe.linkAddr   = tailPtr[wrDest];
    strobe.linkData   = freeHead;
    strobe.freeWr     = deq;
    strobe.freeWrAddr = freeWr;
    strobe.freeData   = headPtr[gIdx];
    strobe.freeRdAddr = freeRd;
    strobe.rdEn       = deq;
    strobe.rdAddr     = headPtr[gIdx];
  end

  for (genvar j = 0; j < VQ_OUTPUTS; j++) begin : g_queue
    logic addHere, takeHere;
    assign addHere  = enq && (wrDest == DEST_W'(j));
    assign takeHere = deq && (gIdx == DEST_W'(j));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        occ[j]     <= '0;
        headPtr[j] <= '0;
        tailPtr[j] <= '0;
      end else begin
        occ[j] <= occ[j] + cnt_t'(addHere) - cnt_t'(takeHere);
        if (takeHere) begin
          if (occ[j] != cnt_t'(1))  headPtr[j] <= linkNext;
          else if (addHere)         headPtr[j] <= freeHead;
        end else if (addHere && occ[j] == '0) begin
          headPtr[j] <= freeHead;
        end
        if (addHere) tailPtr[j] <= freeHead;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeRd   <= '0;
      freeWr   <= '0;
      freeCnt  <= cnt_t'(VQ_SLOTS);
      grantErr <= 1'b0;
    end else begin
      if (enq) freeRd <= (32'(freeRd) == VQ_SLOTS - 1) ? '0 : freeRd + 1'b1;
      if (deq) freeWr <= (32'(freeWr) == VQ_SLOTS - 1) ? '0 : freeWr + 1'b1;
      freeCnt  <= freeCnt + cnt_t'(deq) - cnt_t'(enq);
      if ((grant != '0) && !deq) grantErr <= 1'b1;
    end
  end

  logic [CNT_W+DEST_W:0] occSum;
  always_comb begin
    occSum = '0;
    for (int j = 0; j < VQ_OUTPUTS; j++) occSum = occSum + (CNT_W+DEST_W+1)'(occ[j]);
  end

  p_slot_conservation_r5: assert property (@(posedge clk) disable iff (!rstN)
    (32'(occSum) + 32'(freeCnt)) == VQ_SLOTS);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    grantErr |=> grantErr);
  p_same_queue_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    sameQ |=> (occ[$past(gIdx)] == $past(occ[gIdx])));
  p_full_refuses_r5: assert property (@(posedge clk) disable iff (!rstN)
    (full && grant == '0) |=> (freeCnt == '0));
endmodule

// File: rtl/vqInputBuffer.sv
module vqInputBuffer
  import vqPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrValid,
  input  logic [DEST_W-1:0]           wrDest,
  input  logic [VQ_CELL_W-1:0]        wrData,
  output logic                        full,
  output logic [VQ_OUTPUTS-1:0]       reqVec,
  output logic [VQ_OUTPUTS*CNT_W-1:0] occFlat,
  input  logic [VQ_OUTPUTS-1:0]       grant,
  output logic                        rdValid,
  output logic [VQ_CELL_W-1:0]        rdData,
  output logic                        grantErr
);
  vqStrobe_t strobe;
  slot_t     freeHead, linkNext;
  cnt_t      occ [VQ_OUTPUTS];

  vqControl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrDest(wrDest), .grant(grant),
    .freeHead(freeHead), .linkNext(linkNext), .strobe(strobe), .occ(occ),
    .full(full), .grantErr(grantErr)
  );

  vqDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .freeHead(freeHead), .linkNext(linkNext), .rdValid(rdValid), .rdData(rdData)
  );

  for (genvar j = 0; j < VQ_OUTPUTS; j++) begin : g_out
    assign reqVec[j]                 = (occ[j] != '0);
    assign occFlat[j*CNT_W +: CNT_W] = occ[j];
  end

  p_grant_served_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot(grant) && (grant & reqVec) != '0) |=> rdValid);
  p_bad_grant_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((grant != '0) && !($onehot(grant) && (grant & reqVec) != '0)) |=> (!rdValid && grantErr));
  p_no_grant_no_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |=> !rdValid);
endmodule

// File: tb/tb_vqInputBuffer.sv
module tb_vqInputBuffer;
  import vqPkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrValid = 1'b0;
  logic [DEST_W-1:0] wrDest = '0;
  logic [VQ_CELL_W-1:0] wrData = '0;
  logic [VQ_OUTPUTS-1:0] grant = '0;
  logic full, rdValid, grantErr;
  logic [VQ_OUTPUTS-1:0] reqVec;
  logic [VQ_OUTPUTS*CNT_W-1:0] occFlat;
  logic [VQ_CELL_W-1:0] rdData;

  vqInputBuffer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [VQ_CELL_W-1:0] mQ [VQ_OUTPUTS][VQ_SLOTS];
  int mCnt [VQ_OUTPUTS];
  bit mErr = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int total();
    int s = 0;
    for (int j = 0; j < VQ_OUTPUTS; j++) s += mCnt[j];
    return s;
  endfunction

  task automatic checkAll(input bit expRd, input logic [VQ_CELL_W-1:0] expData);
    chk("R3 rdValid", rdValid, expRd);
    if (expRd) chk("R3 rdData", rdData, expData);
    for (int j = 0; j < VQ_OUTPUTS; j++) begin
      chk("R1 count", occFlat[j*CNT_W +: CNT_W], mCnt[j]);
      chk("R2 request", reqVec[j], mCnt[j] > 0);
    end
    chk("R5 full", full, total() == VQ_SLOTS);
    chk("R7 grantErr", grantErr, mErr);
  endtask

  // Drive after a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic doCycle(input bit wv, input int d, input logic [VQ_CELL_W-1:0] dat,
                         input logic [VQ_OUTPUTS-1:0] g);
    bit accept, deqOk;
    int gi = 0;
    logic [VQ_CELL_W-1:0] expData = '0;
    wrValid = wv; wrDest = DEST_W'(d); wrData = dat; grant = g;
    accept = wv && (total() < VQ_SLOTS);
    for (int j = 0; j < VQ_OUTPUTS; j++) if (g[j]) gi = j;
    deqOk = ($countones(g) == 1) && (mCnt[gi] > 0);
    if (g != '0 && !deqOk) mErr = 1;
    if (deqOk) begin
      expData = mQ[gi][0];
      for (int k = 0; k < VQ_SLOTS - 1; k++) mQ[gi][k] = mQ[gi][k+1];
      mCnt[gi]--;
    end
    if (accept) begin
      mQ[d][mCnt[d]] = dat;
      mCnt[d]++;
    end
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0; grant = '0;
    checkAll(deqOk, expData);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < VQ_OUTPUTS; j++) mCnt[j] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll(1'b0, '0); // R8 reset state

    // R1 R5: fill two cells per output, reaching capacity
    for (int k = 0; k < VQ_SLOTS / VQ_OUTPUTS; k++)
      for (int d = 0; d < VQ_OUTPUTS; d++)
        doCycle(1, d, VQ_CELL_W'(16'h100 * d + k), '0);
    chk("R5 full at capacity", full, 1);
    doCycle(1, 1, 16'hDEAD, '0); // R5 refused while full
    // R3 R4: drain from highest output downward, arrival order within each
    for (int k = 0; k < VQ_SLOTS / VQ_OUTPUTS; k++)
      for (int d = VQ_OUTPUTS - 1; d >= 0; d--)
        doCycle(0, 0, '0, VQ_OUTPUTS'(1) << d);
    // R9: whole capacity refilled into one queue, then drained
    for (int k = 0; k < VQ_SLOTS; k++) doCycle(1, 1, VQ_CELL_W'(16'h500 + k), '0);
    chk("R9 refill full", full, 1);
    for (int k = 0; k < VQ_SLOTS; k++) doCycle(0, 0, '0, 4'b0010);
    // R6: write and serve queue 2 together with one cell present
    doCycle(1, 2, 16'h0A01, '0);
    doCycle(1, 2, 16'h0A02, 4'b0100);
    chk("R6 count held", occFlat[2*CNT_W +: CNT_W], 1);
    doCycle(0, 0, '0, 4'b0100);
    // R7: grant on empty queue 0 in the same cycle as its first write
    doCycle(1, 0, 16'h0B01, 4'b0001);
    chk("R7 err raised", grantErr, 1);
    doCycle(0, 0, '0, 4'b0001);
    doCycle(0, 0, '0, 4'b0011); // R7 multi-hot ignored
    chk("R7 err sticky", grantErr, 1);

    // Mixed pseudo-random traffic
    for (int n = 0; n < 600; n++) begin
      int gs;
      logic [VQ_OUTPUTS-1:0] g;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gs = int'(lfsr[7:5]);
      g = (gs < VQ_OUTPUTS) ? (VQ_OUTPUTS'(1) << gs) : (gs == 7) ? VQ_OUTPUTS'(3) : '0;
      doCycle(lfsr[0] | lfsr[8], int'(lfsr[2:1]), lfsr ^ 16'h5A5A, g);
    end

    // R8: reset clears everything
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    for (int j = 0; j < VQ_OUTPUTS; j++) mCnt[j] = 0;
    mErr = 0;
    checkAll(1'b0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule